// File: doc/BRIEF.md
# Clamp-Period Auto-Offset Controller

This block closes a digital feedback loop around the offset setting of a multi-channel video converter front end. While the clamp (black-reference) pulse is high, each channel captures its 8-bit converter output. When the pulse ends, the block compares the last captured value with that channel's programmable target code. It then moves the channel's offset word one step toward the target: up when the sample is low, down when it is high, and not at all when they match. Corrections can be applied on every clamp, on every 16th clamp or on every 64th clamp. A hold input freezes the loop. Typical targets are a small black code such as 4 on every channel for RGB input. For component input, luma uses 4 and the two colour-difference channels sit at 128.

When the loop is switched off, the offset word for each channel comes straight from a manual offset-binary input, where 128 means zero offset. Target codes then have no effect. When the loop is switched on, a signed 7-bit brightness value is added to each pixel sample and the result is clipped to 0..255. With the loop off, pixels pass through unchanged.

One shared sequencer runs four states. `S_OFF` is the loop-disabled state; it leaves to `S_WAIT` when enable is 1. `S_WAIT` goes to `S_SAMPLE` on a rising clamp edge. `S_SAMPLE` stays while clamp is high and goes to `S_APPLY` on the first cycle clamp is low. `S_APPLY` always returns to `S_WAIT`. Every state goes to `S_OFF` whenever enable is 0. A rising clamp edge seen in `S_APPLY` is not counted, so clamp pulses must be at least two cycles apart.

Top module: `auto_offset_ctrl`

## Requirements
- R1: With `auto_en`=0, each channel's `offset_out` byte equals its `manual_offset` byte, and clamp pulses and target codes do not change it.
- R2: At the first cycle with `auto_en`=1 after it was 0, every channel's `offset_out` is 128 (0x80).
- R3: In auto mode a correction compares the `adc_data` value at the last clock edge where `clamp` was 1 with the target code. If the sample is below the target, the offset rises by 1; if above, it falls by 1; if equal, it is unchanged. The new offset is visible after the second rising edge that samples `clamp` low.
- R4: The auto offset saturates at 0 and at 255 and never wraps.
- R5: `rate_sel` 2'b00 corrects at every clamp, 2'b01 at every 16th clamp and 2'b10 at every 64th clamp. Counting restarts whenever `rate_sel` or `auto_en` changes, so the first correction falls on the 16th (or 64th) clamp after the change.
- R6: `rate_sel` 2'b11 makes no corrections.
- R7: While `hold`=1 no correction is made and `offset_out` stays constant; corrections resume at the selected rate once `hold`=0.
- R8: With `auto_en`=1, `pix_out` one cycle later equals `adc_data` plus the sign-extended 7-bit two's-complement `bright_adj` (range -64..+63), clipped to 0..255. A brightness of 0 passes data unchanged.
- R9: With `auto_en`=0, `pix_out` one cycle later equals `adc_data` whatever `bright_adj` holds.
- R10: During reset `pix_out` is 0 and the auto offset is 128; `offset_out` follows R1 or R2 according to `auto_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| auto_en | input | 1 | 1 = closed-loop offset mode |
| hold | input | 1 | 1 = freeze the loop offset |
| rate_sel | input | 2 | Correction rate: 00 each, 01 every 16th, 10 every 64th clamp, 11 none |
| clamp | input | 1 | Black-reference pulse |
| adc_data | input | NUM_CH*8 | Converter samples, channel 0 in the low byte |
| target_code | input | NUM_CH*8 | Per-channel desired clamp code |
| manual_offset | input | NUM_CH*8 | Per-channel offset-binary manual offset |
| bright_adj | input | NUM_CH*7 | Per-channel signed brightness |
| offset_out | output | NUM_CH*8 | Per-channel offset word to the analog offset stage |
| pix_out | output | NUM_CH*8 | Per-channel pixel data after the brightness adder |

## Verification
A corrupted loop accumulator or a wrong compare direction shows on `offset_out` two edges after the clamp ends, as a step of the wrong sign or of more than one LSB. A broken interval counter stays hidden until the 16th or 64th clamp, where a step arrives early, late or never. Because of this, the bench counts exact clamp numbers around every rate change. A brightness path fault shows on `pix_out` after one cycle, most clearly at the clip limits.

// File: rtl/acoff_pkg.sv
package acoff_pkg;
    typedef enum logic [1:0] {
        S_OFF,
        S_WAIT,
        S_SAMPLE,
        S_APPLY
    } seq_state_t;
endpackage

// File: rtl/acoff_rate_gate.sv
module acoff_rate_gate #(
    parameter int unsigned DIV_A = 16,
    parameter int unsigned DIV_B = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       auto_en,
    input  logic [1:0] rate_sel,
    input  logic       clamp_evt,
    output logic       due
);
    localparam int unsigned CNT_W = $clog2(DIV_B);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;
    logic             valid;
    logic [1:0]       rate_q;
    logic             en_q;
    logic             changed;

    assign changed = (rate_sel != rate_q) || (auto_en != en_q);

    always_comb begin
        unique case (rate_sel)
            2'b00:   begin last = '0;                 valid = 1'b1; end
            2'b01:   begin last = CNT_W'(DIV_A - 1);  valid = 1'b1; end
            2'b10:   begin last = CNT_W'(DIV_B - 1);  valid = 1'b1; end
            default: begin last = '0;                 valid = 1'b0; end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            rate_q <= 2'b00;
            en_q   <= 1'b0;
            due    <= 1'b0;
        end else begin
            rate_q <= rate_sel;
            en_q   <= auto_en;
            if (changed) begin
                cnt <= '0;
                due <= 1'b0;
            end else if (clamp_evt) begin
                if (valid && cnt == last) begin
                    cnt <= '0;
                    due <= 1'b1;
                end else begin
                    cnt <= CNT_W'(cnt + 1'b1);
                    due <= 1'b0;
                end
            end
        end
    end

    // R6: an invalid rate code never arms a correction
    p_rate11_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rate_sel) == 2'b11) |-> !due);
endmodule

// File: rtl/acoff_seq.sv
module acoff_seq
    import acoff_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic auto_en,
    input  logic clamp,
    input  logic hold,
    input  logic due,
    output logic clamp_evt,
    output logic smp_en,
    output logic apply
);
    seq_state_t st;
    seq_state_t st_nx;
    logic       clamp_q;
    logic       rise;

    assign rise = clamp && !clamp_q;

    always_comb begin
        unique case (st)
            S_OFF:    st_nx = auto_en ? S_WAIT : S_OFF;
            S_WAIT:   st_nx = rise ? S_SAMPLE : S_WAIT;
            S_SAMPLE: st_nx = clamp ? S_SAMPLE : S_APPLY;
            S_APPLY:  st_nx = S_WAIT;
            default:  st_nx = S_OFF;
        endcase
        if (!auto_en) st_nx = S_OFF;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= S_OFF;
            clamp_q <= 1'b0;
        end else begin
            st      <= st_nx;
            clamp_q <= clamp;
        end
    end

    always_comb begin
        clamp_evt = auto_en && (st == S_WAIT) && rise;
        smp_en    = auto_en && clamp && (((st == S_WAIT) && rise) || (st == S_SAMPLE));
        apply     = auto_en && (st == S_APPLY) && due && !hold;
    end

    // R3: a correction slot always follows a sampling window
    p_apply_after_sample_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_APPLY) |-> ($past(st) == S_SAMPLE));
endmodule

// File: rtl/acoff_chan.sv
module acoff_chan #(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned BRIGHT_W = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                auto_en,
    input  logic                smp_en,
    input  logic                apply,
    input  logic [DATA_W-1:0]   adc,
    input  logic [DATA_W-1:0]   target,
    input  logic [DATA_W-1:0]   manual,
    input  logic [BRIGHT_W-1:0] bright,
    output logic [DATA_W-1:0]   offset,
    output logic [DATA_W-1:0]   pix
);
    localparam int unsigned SUM_W = DATA_W + 2;
    localparam logic [DATA_W-1:0] MID  = DATA_W'(1 << (DATA_W - 1));
    localparam logic [DATA_W-1:0] TOP  = {DATA_W{1'b1}};

    logic [DATA_W-1:0]       smp;
    logic [DATA_W-1:0]       acc;
    logic signed [SUM_W-1:0] sum;
    logic [DATA_W-1:0]       clipped;

    always_comb begin
        sum = $signed({2'b00, adc}) +
              $signed({{(SUM_W - BRIGHT_W){bright[BRIGHT_W-1]}}, bright});
        if (sum < 0)
            clipped = '0;
        else if (sum > $signed({2'b00, TOP}))
            clipped = TOP;
        else
            clipped = sum[DATA_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp <= '0;
            acc <= MID;
            pix <= '0;
        end else begin
            if (smp_en) smp <= adc;
            if (!auto_en) begin
                acc <= MID;
            end else if (apply) begin
                if (smp < target && acc != TOP)
                    acc <= acc + 1'b1;
                else if (smp > target && acc != '0)
                    acc <= acc - 1'b1;
            end
            pix <= auto_en ? clipped : adc;
        end
    end

    assign offset = auto_en ? acc : manual;

    // R3: the loop moves at most one LSB per cycle
    p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && $past(auto_en)) |->
        (({1'b0, acc} == {1'b0, $past(acc)}) ||
         ({1'b0, acc} == {1'b0, $past(acc)} + 1'b1) ||
         ({1'b0, acc} + 1'b1 == {1'b0, $past(acc)})));

    // R4: no wrap from the top code to the bottom code
    p_no_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && $past(auto_en) && ($past(acc) == TOP)) |-> (acc != '0));

    // R2: loop starts from midscale
    p_start_mid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && !$past(auto_en)) |-> (acc == MID));
endmodule

// File: rtl/auto_offset_ctrl.sv
module auto_offset_ctrl #(
    parameter int unsigned NUM_CH   = 3,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned BRIGHT_W = 7,
    parameter int unsigned DIV_A    = 16,
    parameter int unsigned DIV_B    = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         auto_en,
    input  logic                         hold,
    input  logic [1:0]                   rate_sel,
    input  logic                         clamp,
    input  logic [NUM_CH*DATA_W-1:0]     adc_data,
    input  logic [NUM_CH*DATA_W-1:0]     target_code,
    input  logic [NUM_CH*DATA_W-1:0]     manual_offset,
    input  logic [NUM_CH*BRIGHT_W-1:0]   bright_adj,
    output logic [NUM_CH*DATA_W-1:0]     offset_out,
    output logic [NUM_CH*DATA_W-1:0]     pix_out
);
    logic clamp_evt;
    logic smp_en;
    logic apply;
    logic due;

    acoff_rate_gate #(.DIV_A(DIV_A), .DIV_B(DIV_B)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .auto_en   (auto_en),
        .rate_sel  (rate_sel),
        .clamp_evt (clamp_evt),
        .due       (due)
    );

    acoff_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .auto_en   (auto_en),
        .clamp     (clamp),
        .hold      (hold),
        .due       (due),
        .clamp_evt (clamp_evt),
        .smp_en    (smp_en),
        .apply     (apply)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        acoff_chan #(.DATA_W(DATA_W), .BRIGHT_W(BRIGHT_W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .auto_en (auto_en),
            .smp_en  (smp_en),
            .apply   (apply),
            .adc     (adc_data[c*DATA_W +: DATA_W]),
            .target  (target_code[c*DATA_W +: DATA_W]),
            .manual  (manual_offset[c*DATA_W +: DATA_W]),
            .bright  (bright_adj[c*BRIGHT_W +: BRIGHT_W]),
            .offset  (offset_out[c*DATA_W +: DATA_W]),
            .pix     (pix_out[c*DATA_W +: DATA_W])
        );
    end

    // R7: a hold seen on the previous edge leaves every loop offset unchanged
    p_hold_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && $past(auto_en) && $past(hold)) |-> $stable(offset_out));
endmodule

// File: tb/test_auto_offset_ctrl.sv
module test_auto_offset_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        auto_en;
    logic        hold;
    logic [1:0]  rate_sel;
    logic        clamp;
    logic [23:0] adc_data;
    logic [23:0] target_code;
    logic [23:0] manual_offset;
    logic [20:0] bright_adj;
    logic [23:0] offset_out;
    logic [23:0] pix_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [7:0] exp_off [3];
    logic [7:0] tg [3];

    localparam logic [15:0] VEC [0:7] = '{16'h0A04, 16'h0404, 16'h0004, 16'hC880,
                                          16'h8080, 16'h3280, 16'hFFFE, 16'h0101};

    always #2 clk = ~clk;

    auto_offset_ctrl i_auto_offset_ctrl (
        .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .hold(hold), .rate_sel(rate_sel),
        .clamp(clamp), .adc_data(adc_data), .target_code(target_code),
        .manual_offset(manual_offset), .bright_adj(bright_adj),
        .offset_out(offset_out), .pix_out(pix_out)
    );

    task automatic tick(); @(negedge clk); endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_off(input string req);
        for (int c = 0; c < 3; c++)
            chk(req, offset_out[c*8 +: 8], exp_off[c]);
    endtask

    task automatic set_tgt(input logic [7:0] t0, t1, t2);
        tg[0] = t0; tg[1] = t1; tg[2] = t2;
        target_code = {t2, t1, t0};
    endtask

    function automatic logic [7:0] mstep(input logic [7:0] cur, smp, tgt);
        if (smp < tgt && cur != 8'hFF) return cur + 8'd1;
        if (smp > tgt && cur != 8'h00) return cur - 8'd1;
        return cur;
    endfunction

    // two clamp-high cycles; only the second sample counts (R3)
    task automatic pulse(input logic [7:0] a0, a1, a2, input bit corr);
        clamp = 1'b1;
        adc_data = {~a2, ~a1, ~a0};
        tick();
        adc_data = {a2, a1, a0};
        tick();
        clamp = 1'b0;
        adc_data = 24'h555555;
        tick(); tick(); tick();
        if (corr) begin
            exp_off[0] = mstep(exp_off[0], a0, tg[0]);
            exp_off[1] = mstep(exp_off[1], a1, tg[1]);
            exp_off[2] = mstep(exp_off[2], a2, tg[2]);
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 0; auto_en = 0; hold = 0; rate_sel = 2'b00; clamp = 0;
        adc_data = 24'h0; manual_offset = {8'h70, 8'h80, 8'h90};
        bright_adj = {7'h7B, 7'h40, 7'h3F};
        set_tgt(8'd200, 8'd200, 8'd200);
        exp_off[0] = 8'h90; exp_off[1] = 8'h80; exp_off[2] = 8'h70;
        tick(); tick(); tick();
        // R10: reset state
        chk("R10 pix reset", pix_out[7:0], 8'd0);
        chk_off("R10 offset in reset");
        rst_n = 1;
        adc_data = {8'd100, 8'd10, 8'd250};
        tick();
        // R9: brightness ignored with loop off
        chk("R9 pass ch0", pix_out[7:0],   8'd250);
        chk("R9 pass ch1", pix_out[15:8],  8'd10);
        chk("R9 pass ch2", pix_out[23:16], 8'd100);
        // R1: clamps ignored in manual mode
        pulse(8'd0, 8'd0, 8'd0, 0);
        pulse(8'd0, 8'd0, 8'd0, 0);
        chk_off("R1 manual kept");

        // R2: enable starts at midscale
        auto_en = 1;
        exp_off[0] = 8'd128; exp_off[1] = 8'd128; exp_off[2] = 8'd128;
        tick();
        chk_off("R2 midscale");

        // R3: table of compare cases at rate 00
        for (int i = 0; i < 8; i++) begin
            logic [7:0] a, t;
            a = VEC[i][15:8];
            t = VEC[i][7:0];
            set_tgt(t, t, t);
            pulse(a, t, a ^ 8'hFF, 1);
            chk_off("R3 step direction");
        end

        // R4: saturate high then low
        set_tgt(8'd200, 8'd200, 8'd200);
        for (int i = 0; i < 130; i++) pulse(8'd0, 8'd0, 8'd0, 1);
        chk("R4 model top", exp_off[0], 8'hFF);
        chk_off("R4 sat high");
        set_tgt(8'd0, 8'd0, 8'd0);
        for (int i = 0; i < 260; i++) pulse(8'd255, 8'd255, 8'd255, 1);
        chk("R4 model bottom", exp_off[0], 8'h00);
        chk_off("R4 sat low");

        // R7: hold freezes, release resumes
        set_tgt(8'd200, 8'd200, 8'd200);
        hold = 1;
        for (int i = 0; i < 5; i++) pulse(8'd0, 8'd0, 8'd0, 0);
        chk_off("R7 held");
        hold = 0;
        pulse(8'd0, 8'd0, 8'd0, 1);
        chk_off("R7 resumed");

        // R5: every 16th clamp
        rate_sel = 2'b01; tick();
        for (int i = 0; i < 15; i++) pulse(8'd0, 8'd0, 8'd0, 0);
        chk_off("R5 no step before 16th");
        pulse(8'd0, 8'd0, 8'd0, 1);
        chk_off("R5 step at 16th");
        // R5: count restarts on a mode change
        for (int i = 0; i < 10; i++) pulse(8'd0, 8'd0, 8'd0, 0);
        rate_sel = 2'b10; tick();
        rate_sel = 2'b01; tick();
        for (int i = 0; i < 15; i++) pulse(8'd0, 8'd0, 8'd0, 0);
        chk_off("R5 restart no early step");
        pulse(8'd0, 8'd0, 8'd0, 1);
        chk_off("R5 restart step at 16th");
        // R5: every 64th clamp
        rate_sel = 2'b10; tick();
        for (int i = 0; i < 63; i++) pulse(8'd0, 8'd0, 8'd0, 0);
        chk_off("R5 no step before 64th");
        pulse(8'd0, 8'd0, 8'd0, 1);
        chk_off("R5 step at 64th");

        // R6: invalid code never steps
        rate_sel = 2'b11; tick();
        for (int i = 0; i < 70; i++) pulse(8'd0, 8'd0, 8'd0, 0);
        chk_off("R6 invalid rate quiet");

        // R8: brightness adder with clipping
        adc_data = {8'd100, 8'd10, 8'd250};
        bright_adj = {7'h7B, 7'h40, 7'h3F};
        tick();
        chk("R8 clip high", pix_out[7:0],   8'd255);
        chk("R8 clip low",  pix_out[15:8],  8'd0);
        chk("R8 minus 5",   pix_out[23:16], 8'd95);
        adc_data = {8'd255, 8'd128, 8'd7};
        bright_adj = 21'h0;
        tick();
        chk("R8 zero ch0", pix_out[7:0],   8'd7);
        chk("R8 zero ch1", pix_out[15:8],  8'd128);
        chk("R8 zero ch2", pix_out[23:16], 8'd255);
        adc_data = {8'd0, 8'd0, 8'd100};
        bright_adj = {7'h00, 7'h00, 7'h03};
        tick();
        chk("R8 plus 3", pix_out[7:0], 8'd103);

        // R9 and R1 again after leaving auto mode
        auto_en = 0;
        bright_adj = {7'h7B, 7'h40, 7'h3F};
        adc_data = {8'd100, 8'd10, 8'd250};
        exp_off[0] = 8'h90; exp_off[1] = 8'h80; exp_off[2] = 8'h70;
        tick();
        chk("R9 off ch0", pix_out[7:0], 8'd250);
        chk_off("R1 back to manual");
        // R2: re-enable restarts at midscale
        auto_en = 1;
        exp_off[0] = 8'd128; exp_off[1] = 8'd128; exp_off[2] = 8'd128;
        tick();
        chk_off("R2 re-enable midscale");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule